// File: doc/BRIEF.md
# Text Mode Character Generator

This block turns a character screen into a one-bit pixel stream. It keeps its own position inside the character grid, reads a 7-bit character code from an internal screen buffer, looks up the matching 8-pixel row of that glyph in a built-in 128-glyph font, and shifts that row out most significant bit first, one pixel per clock. The default screen is 80 columns by 40 text rows. Glyph cells are 8 pixels wide and 12 lines tall.

The surrounding timing logic supplies three signals. `line_end` is a one-cycle pulse in the last clock of every scan line. `frame_end` is a one-cycle pulse in the last clock of every frame. `blank` is a level that marks cycles whose pixel must be dark. A separate write port loads character codes into the buffer at any time and does not affect the read path.

Horizontal position is tracked by a two-state machine. `H_SCAN` steps through the columns. The transition `col_exhausted` moves it to `H_PAST` after the eighth pixel of the last column. The transition `line_restart` returns it to `H_SCAN` on `line_end` or `frame_end`. Vertical position is tracked by a second machine. `V_SCAN` steps through glyph lines and text rows. The transition `rows_exhausted` moves it to `V_PAST` at the `line_end` that closes the last glyph line of the last text row. The transition `frame_restart` returns it to `V_SCAN` on `frame_end`.

Top module: `txt_chargen`

## Requirements
- R1: While reset is asserted, and for the first three cycles after it is released, `pix` is 0. After release, the position is column 0, pixel 0, glyph line 0, text row 0.
- R2: The pixel output lags the position by three clocks. For position (row, col, line, p) in cycle k, `pix` in cycle k+3 equals bit 7-p of the glyph row, so the leftmost pixel of a cell is the glyph row's MSB.
- R3: The pixel index counts 0 to 7 every clock. The column advances once every 8 clocks, from 0 to COLS-1. The buffer is read at address row*COLS + col.
- R4: Each `line_end` advances the glyph line. After line 11 the glyph line returns to 0 and the text row advances.
- R5: The font row for code c and line l is {1'b0, c} XOR (l << 4). It is fetched from ROM address c*12 + l.
- R6: A `line_end` in any cycle returns the position to column 0, pixel 0 in the next cycle, even in the middle of a line.
- R7: A `frame_end` in any cycle returns column, pixel, glyph line and text row to 0 in the next cycle. It takes precedence over `line_end`.
- R8: When `blank` is high in cycle k, `pix` is 0 in cycle k+3.
- R9: After the last column's eighth pixel, `pix` stays 0 until the next `line_end`. After the last line of the last text row, `pix` stays 0 until the next `frame_end`.
- R10: When `wr_en` is high, `wr_data` is stored at `wr_addr`. Later reads of that cell show the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | Pulse in the last cycle of a scan line |
| frame_end | input | 1 | Pulse in the last cycle of a frame |
| blank | input | 1 | Forces the pixel for this cycle dark |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W | Buffer cell, row*COLS + col |
| wr_data | input | 7 | Character code to store |
| pix | output | 1 | Serial pixel, three cycles behind the position |

## Verification
A wrong column or pixel count shows at the ports within one cell as a glyph row that is shifted or drawn from the neighbouring cell. A wrong glyph-line or text-row count shows at the first pixel of the next line, because that pixel comes from the wrong font line or buffer row. Errors in the past-edge states show as lit pixels in the overscan region of the next line or frame when `blank` is held low there. Because every pixel depends on the full address chain, each cycle's output is compared against an arithmetic model, across complete frames and across early line and frame restarts.

// File: rtl/txt_pkg.sv
package txt_pkg;
    localparam int GLYPH_W = 8;
    localparam int GLYPH_H = 12;
    localparam int GLYPHS  = 128;
    localparam int CODE_W  = $clog2(GLYPHS);
    localparam int LINE_W  = $clog2(GLYPH_H);
    localparam int PX_W    = $clog2(GLYPH_W);
    localparam int ROM_AW  = $clog2(GLYPHS * GLYPH_H);

    typedef enum logic { H_SCAN, H_PAST } hstate_e;
    typedef enum logic { V_SCAN, V_PAST } vstate_e;

    // Computed font: code in the low bits, line number in the high nibble
    function automatic logic [GLYPH_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                     input logic [LINE_W-1:0] line);
        return {1'b0, code} ^ {line, 4'b0000};
    endfunction
endpackage

// File: rtl/txt_scan_ctr.sv
module txt_scan_ctr
    import txt_pkg::*;
#(
    parameter int COLS  = 80,
    parameter int ROWS  = 40,
    parameter int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic             frame_end,
    output logic [PX_W-1:0]  px_o,
    output logic [COL_W-1:0] col_o,
    output logic [LINE_W-1:0] gline_o,
    output logic [ROW_W-1:0] row_o,
    output logic             visible_o
);
    localparam logic [PX_W-1:0]   PX_LAST   = PX_W'(GLYPH_W - 1);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(GLYPH_H - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

    hstate_e           hst, hst_nx;
    vstate_e           vst, vst_nx;
    logic [PX_W-1:0]   px, px_nx;
    logic [COL_W-1:0]  col, col_nx;
    logic [LINE_W-1:0] gline, gline_nx;
    logic [ROW_W-1:0]  row, row_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst   <= H_SCAN;
            vst   <= V_SCAN;
            px    <= '0;
            col   <= '0;
            gline <= '0;
            row   <= '0;
        end else begin
            hst   <= hst_nx;
            vst   <= vst_nx;
            px    <= px_nx;
            col   <= col_nx;
            gline <= gline_nx;
            row   <= row_nx;
        end
    end

    // Next state and counters
    always_comb begin
        hst_nx   = hst;
        vst_nx   = vst;
        px_nx    = px;
        col_nx   = col;
        gline_nx = gline;
        row_nx   = row;

        unique case (hst)
            H_SCAN: begin
                if (px == PX_LAST) begin
                    px_nx = '0;
                    if (col == COL_LAST) begin
                        col_nx = '0;
                        hst_nx = H_PAST;          // col_exhausted
                    end else begin
                        col_nx = col + 1'b1;
                    end
                end else begin
                    px_nx = px + 1'b1;
                end
            end
            H_PAST: begin
                px_nx  = '0;
                col_nx = '0;
            end
        endcase

        if (line_end) begin
            hst_nx = H_SCAN;                       // line_restart
            px_nx  = '0;
            col_nx = '0;
            unique case (vst)
                V_SCAN: begin
                    if (gline == LINE_LAST) begin
                        gline_nx = '0;
                        if (row == ROW_LAST) begin
                            row_nx = '0;
                            vst_nx = V_PAST;       // rows_exhausted
                        end else begin
                            row_nx = row + 1'b1;
                        end
                    end else begin
                        gline_nx = gline + 1'b1;
                    end
                end
                V_PAST: begin
                    gline_nx = '0;
                    row_nx   = '0;
                end
            endcase
        end

        if (frame_end) begin
            hst_nx   = H_SCAN;                     // line_restart
            vst_nx   = V_SCAN;                     // frame_restart
            px_nx    = '0;
            col_nx   = '0;
            gline_nx = '0;
            row_nx   = '0;
        end
    end

    // Outputs
    always_comb begin
        px_o      = px;
        col_o     = col;
        gline_o   = gline;
        row_o     = row;
        visible_o = (hst == H_SCAN) && (vst == V_SCAN);
    end
endmodule

// File: rtl/txt_charbuf.sv
module txt_charbuf
    import txt_pkg::*;
#(
    parameter int DEPTH  = 3200,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [CODE_W-1:0] rdata
);
    logic [CODE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (int'(raddr) < DEPTH) begin
            rdata <= cells[raddr];
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/txt_fontrom.sv
module txt_fontrom
    import txt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROM_AW-1:0]  addr,
    output logic [GLYPH_W-1:0] row_o
);
    logic [CODE_W-1:0] code_ix;
    logic [LINE_W-1:0] line_ix;

    always_comb begin
        code_ix = CODE_W'(addr / ROM_AW'(GLYPH_H));
        line_ix = LINE_W'(addr % ROM_AW'(GLYPH_H));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_o <= '0;
        end else begin
            row_o <= glyph_row(code_ix, line_ix);
        end
    end
endmodule

// File: rtl/txt_serializer.sv
module txt_serializer
    import txt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GLYPH_W-1:0] din,
    output logic               dout
);
    logic [GLYPH_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= din;
        end else begin
            sh <= {sh[GLYPH_W-2:0], 1'b0};
        end
    end

    assign dout = sh[GLYPH_W-1];
endmodule

// File: rtl/txt_chargen.sv
module txt_chargen
    import txt_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int ROWS   = 40,
    parameter int ADDR_W = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              frame_end,
    input  logic              blank,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [6:0]        wr_data,
    output logic              pix
);
    localparam int DEPTH = COLS * ROWS;
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [PX_W-1:0]    px;
    logic [COL_W-1:0]   col;
    logic [LINE_W-1:0]  gline;
    logic [ROW_W-1:0]   row;
    logic               visible;

    logic [ADDR_W-1:0]  rd_addr;
    logic [CODE_W-1:0]  code_q;
    logic [ROM_AW-1:0]  rom_addr;
    logic [GLYPH_W-1:0] font_q;
    logic               shift_bit;

    logic [PX_W-1:0]    px_q1, px_q2;
    logic [LINE_W-1:0]  gl_q1;
    logic               dark_q1, dark_q2, dark_q3;

    txt_scan_ctr #(
        .COLS (COLS),
        .ROWS (ROWS),
        .COL_W(COL_W),
        .ROW_W(ROW_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .frame_end(frame_end),
        .px_o     (px),
        .col_o    (col),
        .gline_o  (gline),
        .row_o    (row),
        .visible_o(visible)
    );

    assign rd_addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);

    txt_charbuf #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(rd_addr),
        .rdata(code_q)
    );

    assign rom_addr = ROM_AW'(code_q) * ROM_AW'(GLYPH_H) + ROM_AW'(gl_q1);

    txt_fontrom u_rom (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (rom_addr),
        .row_o(font_q)
    );

    txt_serializer u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (px_q2 == '0),
        .din  (font_q),
        .dout (shift_bit)
    );

    // Side pipeline keeping pixel index, glyph line and darkness aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_q1   <= '0;
            px_q2   <= '0;
            gl_q1   <= '0;
            dark_q1 <= 1'b1;
            dark_q2 <= 1'b1;
            dark_q3 <= 1'b1;
        end else begin
            px_q1   <= px;
            px_q2   <= px_q1;
            gl_q1   <= gline;
            dark_q1 <= blank | ~visible;
            dark_q2 <= dark_q1;
            dark_q3 <= dark_q2;
        end
    end

    assign pix = shift_bit & ~dark_q3;
endmodule

// File: rtl/txt_chargen_chk.sv
module txt_chargen_chk #(
    parameter int COLS  = 80,
    parameter int ROWS  = 40,
    parameter int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_end,
    input logic             frame_end,
    input logic             blank,
    input logic             pix,
    input logic [2:0]       px,
    input logic [COL_W-1:0] col,
    input logic [3:0]       gline,
    input logic [ROW_W-1:0] row
);
    assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> ##2 !pix);

    assert_col_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(col) < COLS);

    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_end && !frame_end && px == 3'd7 && int'(col) < COLS - 1)
        |=> (col == $past(col) + 1'b1));

    assert_line_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gline < 4'd12);

    assert_line_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_end && gline == 4'd11) |=> (gline == 4'd0));

    assert_line_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_end) |=> (px == 3'd0 && col == '0));

    assert_frame_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (px == 3'd0 && col == '0 && gline == 4'd0 && row == '0));
endmodule

bind txt_chargen txt_chargen_chk #(
    .COLS(COLS),
    .ROWS(ROWS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_end (line_end),
    .frame_end(frame_end),
    .blank    (blank),
    .pix      (pix),
    .px       (px),
    .col      (col),
    .gline    (gline),
    .row      (row)
);

// File: tb/tb_txt_chargen.sv
module tb_txt_chargen;
    localparam int C  = 10;
    localparam int R  = 4;
    localparam int AW = $clog2(C * R);
    localparam int HT = 8 * C + 12;
    localparam int VT = 12 * R + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_end = 1'b0;
    logic          frame_end = 1'b0;
    logic          blank = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [6:0]    wr_data = '0;
    logic          pix;

    always #2 clk = ~clk;

    txt_chargen #(.COLS(C), .ROWS(R)) dut (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
        .blank(blank), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pix(pix)
    );

    int         nvec = 0;
    int         nbad = 0;
    int         h = 0;
    int         v = 0;
    logic [6:0] bm [C*R];
    logic       qexp [3] = '{1'b0, 1'b0, 1'b0};
    string      tag = "R1";

    function automatic logic [7:0] gref(input int c, input int l);
        return 8'((c ^ (l * 16)) & 255);
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    // Drive the inputs for the current cycle and record its expected pixel
    task automatic apply(input logic le, input logic fe, input logic bl,
                         input logic we, input int wa, input logic [6:0] wd);
        logic       e;
        logic [7:0] g;
        e = 1'b0;
        if (!bl && h < 8 * C && v < 12 * R) begin
            g = gref(int'(bm[(v / 12) * C + h / 8]), v % 12);
            e = g[7 - (h % 8)];
        end
        qexp[0] = qexp[1];
        qexp[1] = qexp[2];
        qexp[2] = e;
        line_end  = le;
        frame_end = fe;
        blank     = bl;
        wr_en     = we;
        wr_addr   = AW'(wa);
        wr_data   = wd;
        if (we) bm[wa] = wd;
        if (fe) begin h = 0; v = 0; end
        else if (le) begin h = 0; v = v + 1; end
        else h = h + 1;
    endtask

    task automatic step(input logic le, input logic fe, input logic bl,
                        input logic we, input int wa, input logic [6:0] wd);
        @(negedge clk);
        nvec++;
        if (pix !== qexp[0]) begin
            nbad++;
            $display("FAIL %s: pix=%0b expected %0b (model h=%0d v=%0d)", tag, pix, qexp[0], h, v);
        end
        apply(le, fe, bl, we, wa, wd);
    endtask

    // mode 0: normal blanking; mode 1: blank low except test windows, rewrite buffer in overscan
    task automatic run_line(input int y, input int mode, input int cut, input logic cut_is_frame);
        for (int x = 0; x < HT; x++) begin
            logic le, fe, bl, we;
            int   wa;
            logic [6:0] wd;
            le = (x == HT - 1) || (x == cut && !cut_is_frame);
            fe = (x == HT - 1 && y == VT - 1) || (x == cut && cut_is_frame);
            if (mode == 1)
                bl = (y == 5 && x >= 16 && x < 24) || (y == 20 && x == 30);
            else
                bl = !(x < 8 * C && y < 12 * R);
            we = (mode == 1) && (y == 12 * R) && (x < C * R);
            wa = we ? x : 0;
            wd = 7'((x * 11 + 64) % 128);
            step(le, fe, bl, we, wa, wd);
            if (le || fe) break;
        end
    endtask

    task automatic run_frame(input int mode, input int cut_line, input int cut_x,
                             input logic cut_is_frame);
        for (int y = 0; y < VT; y++) begin
            run_line(y, mode, (y == cut_line) ? cut_x : -1, cut_is_frame);
            if (y == cut_line && cut_is_frame) break;
        end
    endtask

    initial begin
        #(4 * 200000);
        nbad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        // R1: output dark while reset is held
        tag = "R1";
        repeat (4) begin
            @(negedge clk);
            nvec++;
            if (pix !== 1'b0) begin
                nbad++;
                $display("FAIL R1: pix=%0b expected 0 during reset", pix);
            end
        end
        rst_n = 1'b1;
        apply(1'b0, 1'b0, 1'b1, 1'b0, 0, 7'd0);

        // R10: initial buffer load
        tag = "R10";
        for (int a = 0; a < C * R; a++) begin
            step(1'b0, 1'b0, 1'b1, 1'b1, a, 7'((a * 37 + 5) % 128));
        end
        step(1'b0, 1'b1, 1'b1, 1'b0, 0, 7'd0);

        tag = "R2 R3 R4 R5";
        run_frame(0, -1, -1, 1'b0);
        tag = "R8 R9";
        run_frame(1, -1, -1, 1'b0);
        tag = "R10";
        run_frame(0, -1, -1, 1'b0);
        tag = "R7";
        run_frame(0, 7, 50, 1'b1);
        tag = "R6";
        run_frame(0, 3, 40, 1'b0);
        tag = "R8";
        repeat (4) step(1'b0, 1'b0, 1'b1, 1'b0, 0, 7'd0);
        summary();
    end
endmodule